// File: doc/BRIEF.md
# PLL Retune Sequencer

This block changes the main PLL frequency at run time without exposing the system to the overshoot and undershoot of an in-place retune. Software presents a request with a new PLL setting word, a 5-bit charge-pump code and a wait-mode bit. The sequencer then runs a fixed sequence. It moves the system clock select to the slow reference and strobes the new setting into the PLL. It keeps spread-spectrum dithering off for the whole change and waits until the PLL has settled. Last, it hands the clock back to the PLL and restores the dither state it saw when it accepted the request.

The settle time comes from the charge-pump code. The wait is `LOCK_BASE / (code + 1)` reference cycles, where `LOCK_BASE` is the number of reference cycles in 4 ms. A code of 14 therefore gives about 267 us. The block has two ways to wait. In hardware mode it needs both the lock input and the expiry of a counter loaded with that wait. In polling mode software watches the lock itself and confirms with a go pulse. Requests are refused while synchronous DRAM is in use, because a frequency change is not permitted in that case.

Top module: `pll_retune_seq`

## Requirements
- R1: `clk_sel` (1 = PLL, 0 = slow reference, reset value 1) goes to 0 on the edge that accepts a request. It is 0 for at least the two cycles before and the two cycles after every `pll_cfg_stb` cycle.
- R2: `pll_cfg` changes only in the cycle where `pll_cfg_stb` is high. The strobe lasts one cycle, appears 3 edges after the accepting edge (counting that edge), and `pll_cfg` then carries the requested word.
- R3: While `busy` is high, `dither_en` is 0. When the sequence ends, `dither_en` takes the value `dither_pref` had at acceptance, even if `dither_pref` changed during the sequence. In idle it follows `dither_pref` one cycle late.
- R4: In hardware mode (`sw_poll` = 0) the wait length is L = floor(LOCK_BASE/(`req_cp`+1)). With `pll_lock` held high, `done` is high L+6 edges after the accepting edge. If lock arrives late, `done` comes 2 edges after the first edge that samples `pll_lock` high once the L cycles have elapsed.
- R5: In polling mode (`sw_poll` = 1) the counter is ignored. `done` comes 2 edges after the edge that samples `sw_go` high during the lock wait.
- R6: If the sequence does not complete within 8·L lock-wait cycles, it aborts. `err_timeout` rises 8·L+4 edges after acceptance, `clk_sel` stays 0, `busy` drops, `dither_en` is restored, and `done` is not pulsed.
- R7: When `mem_sync` = 1 (synchronous DRAM), a request is refused. On the next edge `err_reject` is 1, `busy` stays 0, and no strobe, clock-select or configuration change follows.
- R8: Requests while `busy` is high are ignored. `done` is a one-cycle pulse, with `clk_sel` = 1 and `busy` = 0 in that cycle.
- R9: Both error flags hold until the next request is sampled in idle, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Frequency-change request, sampled in idle |
| req_cfg | input | CFG_W | New PLL setting word |
| req_cp | input | 5 | Charge-pump code that sets the wait length |
| sw_poll | input | 1 | 1 = software confirms lock, 0 = hardware wait |
| sw_go | input | 1 | Software lock confirmation in polling mode |
| mem_sync | input | 1 | 1 = synchronous DRAM in use, so requests are refused |
| pll_lock | input | 1 | PLL lock indication |
| dither_pref | input | 1 | Software dither preference |
| clk_sel | output | 1 | System clock source select |
| pll_cfg | output | CFG_W | Setting word driven to the PLL |
| pll_cfg_stb | output | 1 | One-cycle strobe that loads `pll_cfg` into the PLL |
| dither_en | output | 1 | Dither enable to the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_reject | output | 1 | Request refused because of synchronous DRAM |
| err_timeout | output | 1 | Lock wait timed out |

## Verification
Several properties are checked on every cycle:
- the PLL strobe only ever occurs on the slow reference,
- there are two quiet cycles of clock select on each side of the strobe,
- the setting word never moves outside the strobe,
- dithering is off throughout `busy`,
- the shape of the completion pulse,
- the state after a refusal or a timeout.

The exact wait length for a given charge-pump code can only be shown by the bench scenarios. The same holds for late lock, the polling handshake, the timeout at eight times the wait, restoring a dither preference that changed mid-sequence, and ignoring a second request.

// File: rtl/pll_retune_seq.sv
module pll_retune_seq #(
  parameter int CFG_W     = 16,
  parameter int LOCK_BASE = 96000,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CFG_W-1:0] req_cfg,
  input  logic [4:0]       req_cp,
  input  logic             sw_poll,
  input  logic             sw_go,
  input  logic             mem_sync,
  input  logic             pll_lock,
  input  logic             dither_pref,
  output logic             clk_sel,
  output logic [CFG_W-1:0] pll_cfg,
  output logic             pll_cfg_stb,
  output logic             dither_en,
  output logic             busy,
  output logic             done,
  output logic             err_reject,
  output logic             err_timeout
);
  localparam int CNT_W = $clog2(8 * LOCK_BASE + 1);

  typedef enum logic [2:0] {S_IDLE, S_SLOW, S_PROG, S_LOCK, S_BACK} st_t;
  st_t st;

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] lock_len, lock_cnt, wait_cnt, lock_calc;
  logic             poll_q, saved_dith, hold;
  logic             fin, expired;

  assign lock_calc   = CNT_W'(LOCK_BASE / (int'(req_cp) + 1));
  assign busy        = (st != S_IDLE);
  assign pll_cfg_stb = (st == S_PROG);
  assign fin         = poll_q ? sw_go : (pll_lock && lock_cnt == '0);
  assign expired     = (wait_cnt == (lock_len << 3) - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      clk_sel     <= 1'b1;
      pll_cfg     <= CFG_RST;
      cfg_q       <= CFG_RST;
      dither_en   <= 1'b0;
      saved_dith  <= 1'b0;
      poll_q      <= 1'b0;
      hold        <= 1'b0;
      lock_len    <= '0;
      lock_cnt    <= '0;
      wait_cnt    <= '0;
      done        <= 1'b0;
      err_reject  <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          dither_en <= dither_pref;
          if (req_valid) begin
            err_reject  <= mem_sync;
            err_timeout <= 1'b0;
            if (!mem_sync) begin
              st         <= S_SLOW;
              clk_sel    <= 1'b0;
              dither_en  <= 1'b0;
              saved_dith <= dither_pref;
              cfg_q      <= req_cfg;
              poll_q     <= sw_poll;
              lock_len   <= lock_calc;
              hold       <= 1'b0;
            end
          end
        end
        S_SLOW: begin
          hold <= ~hold;
          if (hold) begin
            st      <= S_PROG;
            pll_cfg <= cfg_q;
          end
        end
        S_PROG: begin
          st       <= S_LOCK;
          lock_cnt <= lock_len;
          wait_cnt <= '0;
        end
        S_LOCK: begin
          if (lock_cnt != '0) lock_cnt <= lock_cnt - CNT_W'(1);
          wait_cnt <= wait_cnt + CNT_W'(1);
          if (fin) begin
            st <= S_BACK;
          end else if (expired) begin
            st          <= S_IDLE;
            err_timeout <= 1'b1;
            dither_en   <= saved_dith;
          end
        end
        S_BACK: begin
          st        <= S_IDLE;
          clk_sel   <= 1'b1;
          dither_en <= saved_dith;
          done      <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_retune_seq_chk.sv
module pll_retune_seq_chk #(
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             mem_sync,
  input logic             clk_sel,
  input logic [CFG_W-1:0] pll_cfg,
  input logic             pll_cfg_stb,
  input logic             dither_en,
  input logic             busy,
  input logic             done,
  input logic             err_reject,
  input logic             err_timeout
);
  a_r1_slow_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> !clk_sel);
  a_r1_quiet_before: assert property (@(posedge clk) disable iff (!rst_n)
    pll_cfg_stb |-> (!clk_sel && !$past(clk_sel) && !$past(clk_sel, 2)));
  a_r1_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
    pll_cfg_stb |=> !clk_sel ##1 !clk_sel);
  a_r2_cfg_moves_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_cfg) |-> pll_cfg_stb);
  a_r2_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    pll_cfg_stb |=> !pll_cfg_stb);
  a_r3_dither_off: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dither_en);
  a_r6_abort_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> (!clk_sel && !busy && !done));
  a_r7_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && mem_sync) |=> (err_reject && !busy));
  a_r8_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (clk_sel && !busy));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pll_retune_seq pll_retune_seq_chk #(.CFG_W(CFG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_sync(mem_sync),
  .clk_sel(clk_sel), .pll_cfg(pll_cfg), .pll_cfg_stb(pll_cfg_stb),
  .dither_en(dither_en), .busy(busy), .done(done),
  .err_reject(err_reject), .err_timeout(err_timeout)
);

// File: tb/pll_retune_seq_tb.sv
module pll_retune_seq_tb_top;
  localparam int CFG_W = 8;
  localparam int BASE  = 64;
  localparam int EV_STB = 0, EV_DONE = 1, EV_REJ = 2, EV_TMO = 3;

  typedef struct packed { int kind; int at; } ev_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, sw_poll = 0, sw_go = 0, mem_sync = 0, pll_lock = 0, dither_pref = 0;
  logic [CFG_W-1:0] req_cfg = '0;
  logic [4:0] req_cp = '0;
  logic clk_sel, pll_cfg_stb, dither_en, busy, done, err_reject, err_timeout;
  logic [CFG_W-1:0] pll_cfg;

  int cyc = 0, checks = 0, fails = 0;
  bit finished = 0;
  ev_t exp_q[$];

  pll_retune_seq #(.CFG_W(CFG_W), .LOCK_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cfg(req_cfg),
    .req_cp(req_cp), .sw_poll(sw_poll), .sw_go(sw_go), .mem_sync(mem_sync),
    .pll_lock(pll_lock), .dither_pref(dither_pref), .clk_sel(clk_sel),
    .pll_cfg(pll_cfg), .pll_cfg_stb(pll_cfg_stb), .dither_en(dither_en),
    .busy(busy), .done(done), .err_reject(err_reject), .err_timeout(err_timeout));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic push(input int kind, input int at);
    exp_q.push_back('{kind: kind, at: at});
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic send(input logic [CFG_W-1:0] cfg, input logic [4:0] cp, input logic poll, output int n);
    req_cfg = cfg; req_cp = cp; sw_poll = poll; req_valid = 1'b1;
    n = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: observed events against the expected queue
  logic prev_rej = 0, prev_tmo = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      int kind;
      kind = -1;
      if (pll_cfg_stb) kind = EV_STB;
      else if (done) kind = EV_DONE;
      else if (err_reject && !prev_rej) kind = EV_REJ;
      else if (err_timeout && !prev_tmo) kind = EV_TMO;
      if (kind >= 0) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8", "unexpected event kind", kind, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(e.kind == kind, "R2/R4/R5/R6/R7", "event kind", kind, e.kind);
          chk(e.at == cyc, "R2/R4/R5/R6/R7", "event cycle", cyc, e.at);
        end
      end
      prev_rej = err_reject;
      prev_tmo = err_timeout;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual %0d expected below 20000 cycles", cyc);
    finish_up();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(clk_sel == 1, "R1", "reset clk_sel", clk_sel, 1);
    chk(busy == 0 && done == 0 && pll_cfg_stb == 0, "R8", "reset busy/done/stb", {busy, done, pll_cfg_stb}, 0);
    chk(pll_cfg == 0 && dither_en == 0, "R2", "reset cfg/dither", pll_cfg, 0);

    // R4: hardware wait, cp=14 -> L=4, lock high; R8 second request ignored; R3 restore
    pll_lock = 1; dither_pref = 1;
    repeat (2) @(negedge clk);
    chk(dither_en == 1, "R3", "idle dither follows pref", dither_en, 1);
    send(8'hA5, 5'd14, 1'b0, n);
    push(EV_STB, n + 3); push(EV_DONE, n + 10);
    chk(clk_sel == 0 && busy == 1, "R1", "slow select after accept", clk_sel, 0);
    chk(dither_en == 0, "R3", "dither off while busy", dither_en, 0);
    dither_pref = 0;
    wait_cyc(n + 5);
    req_cfg = 8'h3C; req_valid = 1'b1;   // R8: ignored while busy
    @(negedge clk);
    req_valid = 1'b0;
    wait_cyc(n + 10);
    chk(done == 1 && clk_sel == 1, "R4", "done and PLL select", {done, clk_sel}, 3);
    chk(dither_en == 1, "R3", "dither restored to captured value", dither_en, 1);
    chk(pll_cfg == 8'hA5, "R2", "cfg word", pll_cfg, 8'hA5);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R8", "done one cycle", done, 0);
    chk(pll_cfg == 8'hA5, "R8", "busy request ignored", pll_cfg, 8'hA5);

    // R4: late lock, cp=31 -> L=2
    pll_lock = 0; dither_pref = 1;
    repeat (2) @(negedge clk);
    send(8'h11, 5'd31, 1'b0, n);
    push(EV_STB, n + 3); push(EV_DONE, n + 12);
    wait_cyc(n + 10);
    pll_lock = 1;
    @(negedge clk);
    chk(busy == 1 && done == 0, "R4", "still waiting for lock", busy, 1);
    wait_cyc(n + 12);
    chk(dither_en == 1 && clk_sel == 1, "R3", "late-lock restore", dither_en, 1);

    // R5: polling mode, cp=0 -> L=64 counter ignored
    dither_pref = 0;
    repeat (2) @(negedge clk);
    send(8'h77, 5'd0, 1'b1, n);
    push(EV_STB, n + 3); push(EV_DONE, n + 11);
    wait_cyc(n + 9);
    sw_go = 1;
    @(negedge clk);
    sw_go = 0;
    wait_cyc(n + 11);
    chk(done == 1 && pll_cfg == 8'h77, "R5", "poll completion", pll_cfg, 8'h77);
    chk(dither_en == 0, "R3", "dither stays off when it was off", dither_en, 0);

    // R7: synchronous DRAM refusal
    repeat (2) @(negedge clk);
    mem_sync = 1;
    send(8'h99, 5'd5, 1'b0, n);
    push(EV_REJ, n + 1);
    chk(err_reject == 1 && busy == 0 && clk_sel == 1, "R7", "refused", {err_reject, busy, clk_sel}, 5);
    wait_cyc(n + 5);
    chk(pll_cfg == 8'h77 && clk_sel == 1, "R7", "no change after refusal", pll_cfg, 8'h77);
    mem_sync = 0;

    // R6: timeout, cp=31 -> L=2, no lock; R9 clears reject
    pll_lock = 0; dither_pref = 1;
    repeat (2) @(negedge clk);
    send(8'h42, 5'd31, 1'b0, n);
    push(EV_STB, n + 3); push(EV_TMO, n + 20);
    chk(err_reject == 0, "R9", "reject flag cleared by request", err_reject, 0);
    wait_cyc(n + 20);
    chk(err_timeout == 1 && busy == 0, "R6", "timeout flag", err_timeout, 1);
    chk(clk_sel == 0, "R6", "stays on slow reference", clk_sel, 0);
    chk(dither_en == 1, "R6", "dither restored on abort", dither_en, 1);
    repeat (3) @(negedge clk);
    chk(err_timeout == 1, "R9", "timeout flag held", err_timeout, 1);

    // recovery after abort
    pll_lock = 1;
    send(8'h42, 5'd14, 1'b0, n);
    push(EV_STB, n + 3); push(EV_DONE, n + 10);
    chk(err_timeout == 0, "R9", "timeout flag cleared", err_timeout, 0);
    wait_cyc(n + 10);
    chk(clk_sel == 1 && done == 1, "R4", "recovered sequence", clk_sel, 1);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "all expected events seen", exp_q.size(), 0);
    finish_up();
  end
endmodule